// File: doc/BRIEF.md
# Processor Hot Alert Aggregator

This block merges ten monitored event flags into one active-low alert line that tells a host processor to throttle. The events are peak input current, average input current, two battery discharge-current levels, a comparator pin, low system voltage, adapter removal, battery removal, low input voltage and exit from boost-assist mode. The inputs are flags that digital comparators already produce; the block itself makes no analog measurement. The block filters the five current and comparator flags with programmable deglitch counters. It gates each event with its own enable bit and records every triggering event in a sticky status bit.

A trigger drives the alert low for a minimum number of cycles that a 2-bit code selects. The pulse stretches for as long as any enabled event stays active. In extended mode the alert stays low after the events have gone, until the host strobes the alert-clear input. The low-input-voltage and boost-assist-exit events always latch the alert until the host strobes their own clear input. The low-input-voltage comparison uses a threshold scaled from the setpoint by a 2-bit selection.

Top module: `hotalert_agg`

## Requirements
- R1: After reset `alert_n` is 1 and every `stat` bit is 0.
- R2: A trigger seen at a clock edge drives `alert_n` low from that edge. If no event stays active, the alert stays low for exactly PW_BASE << `pw_sel` cycles (4, 8, 16 or 32 with the default PW_BASE of 4).
- R3: While any enabled event stays active the alert stays low. An event held for L cycles gives a low time of max(L, minimum width).
- R4: With `ext_mode` at 1 the alert stays low after all events have ended. The first edge that samples `clr_alert` at 1, once the minimum width has run out, releases the alert.
- R5: Status bit 8 (low input voltage) and status bit 9 (boost-assist exit) keep the alert low in every mode. Each clears only when its own strobe is sampled (`clr_lowvin`, `clr_exit`) while the event is inactive. A strobe that arrives while the event is active leaves the bit set.
- R6: Event index map: 0 peak current, 1 average current, 2 discharge level 1, 3 discharge level 2, 4 comparator, 5 low system voltage, 6 adapter removed, 7 battery removed, 8 low input voltage, 9 boost-assist exit. Events 0 to 8 trigger only when their `ev_en` bit is 1. Event 9 always triggers and ignores `ev_en[9]`.
- R7: The low-input-voltage event is active while `vbus_lvl` is below a threshold. The threshold is `vin_set` when `vin_lower` is 0, floor(`vin_set`*106/128) (about 83%) when `vin_lower` is 1 and `vin_sel91` is 0, and floor(`vin_set`*117/128) (about 91%) when both are 1.
- R8: The comparator event is active while `cond_in[4]` is low. It arms only after `cond_in[4]` has been seen high since reset, so a high-to-low transition is needed. A pin that has been low ever since reset never triggers.
- R9: Events 0 to 4 each pass through a deglitch filter. The filter asserts only after the raw flag has been high for N = 1 << `dg_code[2i+1:2i]` consecutive samples, and any low sample restarts the count. The filtered flag triggers one edge after the Nth sample.
- R10: Status bits 0 to 7 are sticky. The first edge that samples `clr_alert` at 1 while the event is inactive clears them. A bit whose event is still active stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_in | input | 8 | Raw flags for events 0..7 (bit 4 is the comparator pin level) |
| exit_assist | input | 1 | Boost-assist exit event flag |
| vbus_lvl | input | VW | Measured input voltage code |
| vin_set | input | VW | Input-voltage setpoint code |
| vin_lower | input | 1 | Select a scaled threshold instead of the setpoint |
| vin_sel91 | input | 1 | With vin_lower: 1 selects 91%, 0 selects 83% |
| ev_en | input | 10 | Per-event enable mask (bit 9 ignored) |
| dg_code | input | 10 | 2-bit deglitch code per event 0..4 |
| pw_sel | input | 2 | Minimum pulse width code |
| ext_mode | input | 1 | Hold the alert until host clear |
| clr_alert | input | 1 | Host clear strobe for the alert hold and status bits 0..7 |
| clr_lowvin | input | 1 | Host clear strobe for status bit 8 |
| clr_exit | input | 1 | Host clear strobe for status bit 9 |
| alert_n | output | 1 | Active-low alert |
| stat | output | 10 | Sticky per-event status |

## Verification
A one-shot counter that loads wrongly or fails to decrement shows up as an alert whose low time differs from the arithmetic width. The first pulse after the fault reveals it. A deglitch counter that does not restart on a low sample lets a broken run of high samples through, which sets a status bit within a few cycles. A lost latch or a wrong clear mask releases the alert early, or leaves a status bit stuck after its strobe. The check one cycle after the clear strobe catches either case.

// File: rtl/hotalert_pkg.sv
package hotalert_pkg;
    localparam int NUM_EV    = 10;
    localparam int NUM_DG    = 5;
    localparam int NUM_COND  = 8;
    localparam int EV_PEAK   = 0;
    localparam int EV_AVG    = 1;
    localparam int EV_DCH1   = 2;
    localparam int EV_DCH2   = 3;
    localparam int EV_CMP    = 4;
    localparam int EV_SYSV   = 5;
    localparam int EV_ADPT   = 6;
    localparam int EV_BATT   = 7;
    localparam int EV_LOWVIN = 8;
    localparam int EV_EXIT   = 9;
    localparam int K83       = 106;
    localparam int K91       = 117;
    localparam int KSHIFT    = 7;
endpackage

// File: rtl/hotalert_deglitch.sv
module hotalert_deglitch #(
    parameter int SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  logic [1:0] code,
    output logic       filt
);
    localparam int CW = SHIFT + 5;

    logic [CW-1:0] cnt_d, cnt_q, need;
    logic          filt_d, filt_q;

    assign need = CW'(1) << (CW'(SHIFT) + CW'(code));

    always_comb begin
        cnt_d  = '0;
        filt_d = 1'b0;
        if (raw) begin
            cnt_d  = (cnt_q >= need) ? cnt_q : cnt_q + CW'(1);
            filt_d = (cnt_q + CW'(1)) >= need;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            filt_q <= filt_d;
        end
    end

    assign filt = filt_q;
endmodule

// File: rtl/hotalert_vin_cmp.sv
module hotalert_vin_cmp
    import hotalert_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic [VW-1:0] vbus,
    input  logic [VW-1:0] setpt,
    input  logic          lower,
    input  logic          sel_hi,
    output logic          below
);
    localparam int PW = VW + KSHIFT;

    logic [VW-1:0] t83, t91, thr;

    assign t83 = VW'(({{KSHIFT{1'b0}}, setpt} * PW'(K83)) >> KSHIFT);
    assign t91 = VW'(({{KSHIFT{1'b0}}, setpt} * PW'(K91)) >> KSHIFT);

    always_comb begin
        if (!lower)      thr = setpt;
        else if (sel_hi) thr = t91;
        else             thr = t83;
    end

    assign below = vbus < thr;
endmodule

// File: rtl/hotalert_agg.sv
module hotalert_agg
    import hotalert_pkg::*;
#(
    parameter int VW       = 8,
    parameter int PW_BASE  = 4,
    parameter int DG_SHIFT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_COND-1:0]   cond_in,
    input  logic                  exit_assist,
    input  logic [VW-1:0]         vbus_lvl,
    input  logic [VW-1:0]         vin_set,
    input  logic                  vin_lower,
    input  logic                  vin_sel91,
    input  logic [NUM_EV-1:0]     ev_en,
    input  logic [2*NUM_DG-1:0]   dg_code,
    input  logic [1:0]            pw_sel,
    input  logic                  ext_mode,
    input  logic                  clr_alert,
    input  logic                  clr_lowvin,
    input  logic                  clr_exit,
    output logic                  alert_n,
    output logic [NUM_EV-1:0]     stat
);
    localparam int PW_CW = $clog2(PW_BASE * 8) + 1;

    typedef struct packed {
        logic [PW_CW-1:0]  pw_cnt;
        logic              hold;
        logic              low;
        logic              armed;
        logic [NUM_EV-1:0] stat;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_DG-1:0] dg_raw, dg_filt;
    logic [NUM_EV-1:0] ev_act, en_eff, trig, clr_vec;
    logic              vin_below, any_trig;
    logic [PW_CW-1:0]  pw_w;

    // Deglitch filters for current and comparator events
    always_comb begin
        dg_raw         = cond_in[NUM_DG-1:0];
        dg_raw[EV_CMP] = ~cond_in[EV_CMP] & s_q.armed;
    end

    for (genvar g = 0; g < NUM_DG; g++) begin : g_dg
        hotalert_deglitch #(.SHIFT(DG_SHIFT)) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (dg_raw[g]),
            .code  (dg_code[2*g +: 2]),
            .filt  (dg_filt[g])
        );
    end

    hotalert_vin_cmp #(.VW(VW)) u_vin (
        .vbus   (vbus_lvl),
        .setpt  (vin_set),
        .lower  (vin_lower),
        .sel_hi (vin_sel91),
        .below  (vin_below)
    );

    always_comb begin
        ev_act                       = '0;
        ev_act[NUM_DG-1:0]           = dg_filt;
        ev_act[NUM_COND-1:NUM_DG]    = cond_in[NUM_COND-1:NUM_DG];
        ev_act[EV_LOWVIN]            = vin_below;
        ev_act[EV_EXIT]              = exit_assist;

        en_eff   = ev_en | (NUM_EV'(1) << EV_EXIT);
        trig     = ev_act & en_eff;
        any_trig = |trig;

        clr_vec            = {NUM_EV{clr_alert}};
        clr_vec[EV_LOWVIN] = clr_lowvin;
        clr_vec[EV_EXIT]   = clr_exit;

        pw_w = PW_CW'(PW_BASE) << pw_sel;

        s_d       = s_q;
        s_d.armed = s_q.armed | cond_in[EV_CMP];
        s_d.stat  = trig | (s_q.stat & ~clr_vec);

        if (any_trig && !s_q.low)
            s_d.pw_cnt = pw_w - PW_CW'(1);
        else if (s_q.pw_cnt != '0)
            s_d.pw_cnt = s_q.pw_cnt - PW_CW'(1);
        else
            s_d.pw_cnt = '0;

        s_d.hold = ext_mode & (any_trig | (s_q.hold & ~clr_alert));
        s_d.low  = any_trig | (s_q.pw_cnt != '0) | s_d.hold
                 | s_d.stat[EV_LOWVIN] | s_d.stat[EV_EXIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alert_n = ~s_q.low;
    assign stat    = s_q.stat;
endmodule

// File: rtl/hotalert_agg_chk.sv
module hotalert_agg_chk #(
    parameter int PW_BASE = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        alert_n,
    input logic [9:0]  stat,
    input logic [1:0]  pw_sel,
    input logic [9:0]  ev_en,
    input logic        exit_assist,
    input logic        clr_lowvin
);
    logic        prev_n;
    logic [1:0]  sel_prev;
    logic [15:0] low_len, need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_n   <= 1'b1;
            sel_prev <= 2'd0;
            low_len  <= '0;
            need     <= '0;
        end else begin
            prev_n   <= alert_n;
            sel_prev <= pw_sel;
            if (!alert_n) begin
                if (prev_n) begin
                    low_len <= 16'd1;
                    need    <= 16'(PW_BASE) << sel_prev;
                end else if (low_len != 16'hFFFF) begin
                    low_len <= low_len + 16'd1;
                end
            end
        end
    end

    // R2: a low pulse never ends before its minimum width
    p_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_n && !prev_n) |-> low_len >= need);

    // R6: boost-assist exit triggers regardless of enables
    p_exit_always_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exit_assist |=> (stat[9] && !alert_n));

    // R5: a latched status keeps the alert low
    p_latch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[8] || stat[9]) |-> !alert_n);

    // R5: the low-input status survives without its own clear
    p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[8] && !clr_lowvin) |=> stat[8]);

    // R6: a gated event sets status only when enabled
    p_enable_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[5]) |-> $past(ev_en[5]));
endmodule

bind hotalert_agg hotalert_agg_chk #(.PW_BASE(PW_BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alert_n     (alert_n),
    .stat        (stat),
    .pw_sel      (pw_sel),
    .ev_en       (ev_en),
    .exit_assist (exit_assist),
    .clr_lowvin  (clr_lowvin)
);

// File: tb/hotalert_agg_tb.sv
module hotalert_agg_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cond_in;
    logic       exit_assist;
    logic [7:0] vbus_lvl, vin_set;
    logic       vin_lower, vin_sel91;
    logic [9:0] ev_en, dg_code;
    logic [1:0] pw_sel;
    logic       ext_mode, clr_alert, clr_lowvin, clr_exit;
    logic       alert_n;
    logic [9:0] stat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hotalert_agg u_dut (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .exit_assist(exit_assist),
        .vbus_lvl(vbus_lvl), .vin_set(vin_set), .vin_lower(vin_lower),
        .vin_sel91(vin_sel91), .ev_en(ev_en), .dg_code(dg_code), .pw_sel(pw_sel),
        .ext_mode(ext_mode), .clr_alert(clr_alert), .clr_lowvin(clr_lowvin),
        .clr_exit(clr_exit), .alert_n(alert_n), .stat(stat)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_clr();
        clr_alert = 1'b1; cyc(1); clr_alert = 1'b0;
    endtask

    // Hold event 5 high for hold_len cycles; return the alert low time
    task automatic low_time(input int hold_len, output int w);
        int k;
        w = 0; k = 0;
        cond_in[5] = 1'b1;
        while (k < 300) begin
            @(negedge clk);
            k++;
            if (k == hold_len) cond_in[5] = 1'b0;
            if (!alert_n) w++;
            else break;
        end
    endtask

    initial begin
        rst_n = 1'b0; cond_in = 8'h00; exit_assist = 1'b0;
        vbus_lvl = 8'd255; vin_set = 8'd200; vin_lower = 1'b0; vin_sel91 = 1'b0;
        ev_en = 10'h3FF; dg_code = 10'd0; pw_sel = 2'd0; ext_mode = 1'b0;
        clr_alert = 1'b0; clr_lowvin = 1'b0; clr_exit = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 alert_n", alert_n, 1);
        chk("R1 stat", stat, 0);

        // R8: comparator low since reset never triggers
        cyc(10);
        chk("R8 unarmed alert", alert_n, 1);
        chk("R8 unarmed stat", stat[4], 0);
        cond_in[4] = 1'b1; cyc(3);
        cond_in[4] = 1'b0; cyc(3);
        chk("R8 falling stat", stat[4], 1);
        chk("R8 falling alert", alert_n, 0);
        cond_in[4] = 1'b1; cyc(40); host_clr(); cyc(1);
        chk("R10 cleared stat4", stat[4], 0);
        chk("R10 alert idle", alert_n, 1);

        // R2: width sweep with a single-cycle event
        for (int p = 0; p < 4; p++) begin
            int w;
            pw_sel = 2'(p);
            low_time(1, w);
            chk("R2 min width", w, 4 << p);
            host_clr(); cyc(2);
        end

        // R3: extension while the event persists
        for (int p = 0; p < 2; p++) begin
            for (int L = 1; L <= 12; L++) begin
                int w;
                int wmin;
                pw_sel = 2'(p);
                wmin = 4 << p;
                low_time(L, w);
                chk("R3 extended width", w, (L > wmin) ? L : wmin);
                host_clr(); cyc(2);
            end
        end
        pw_sel = 2'd0;

        // R9: deglitch sweep on event 0
        for (int c = 0; c < 4; c++) begin
            for (int k = 1; k <= (1 << c) + 1; k++) begin
                dg_code[1:0] = 2'(c);
                cond_in[0] = 1'b1; cyc(k);
                cond_in[0] = 1'b0; cyc(3);
                chk("R9 deglitch", stat[0], (k >= (1 << c)) ? 1 : 0);
                cyc(6); host_clr(); cyc(2);
            end
        end
        dg_code[1:0] = 2'd2;
        cond_in[0] = 1'b1; cyc(3); cond_in[0] = 1'b0; cyc(1);
        cond_in[0] = 1'b1; cyc(3); cond_in[0] = 1'b0; cyc(3);
        chk("R9 restart on low", stat[0], 0);
        chk("R9 restart alert", alert_n, 1);
        dg_code = 10'd0;

        // R6: disabled event is ignored
        ev_en[5] = 1'b0;
        cond_in[5] = 1'b1; cyc(3); cond_in[5] = 1'b0; cyc(2);
        chk("R6 disabled alert", alert_n, 1);
        chk("R6 disabled stat", stat[5], 0);
        ev_en[5] = 1'b1;

        // R10: clear while active keeps status
        cond_in[6] = 1'b1; cyc(10); host_clr(); cyc(1);
        chk("R10 active keeps stat", stat[6], 1);
        chk("R3 active keeps alert", alert_n, 0);
        cond_in[6] = 1'b0; cyc(6); host_clr(); cyc(1);
        chk("R10 clears stat", stat[6], 0);

        // R4: extended mode hold
        ext_mode = 1'b1;
        cond_in[7] = 1'b1; cyc(1); cond_in[7] = 1'b0; cyc(40);
        chk("R4 held low", alert_n, 0);
        host_clr();
        chk("R4 released", alert_n, 1);
        chk("R4 stat cleared", stat[7], 0);
        ext_mode = 1'b0; cyc(2);

        // R7 and R5: threshold selection and latching
        for (int m = 0; m < 3; m++) begin
            int thr;
            vin_lower = (m != 0);
            vin_sel91 = (m == 2);
            thr = (m == 0) ? 200 : ((m == 1) ? (200 * 106) / 128 : (200 * 117) / 128);
            for (int d = -1; d <= 1; d++) begin
                vbus_lvl = 8'(thr + d); cyc(2);
                chk("R7 threshold", stat[8], (thr + d < thr) ? 1 : 0);
                vbus_lvl = 8'd255;
                if (thr + d < thr) begin
                    cyc(40);
                    chk("R5 latched low", alert_n, 0);
                    clr_lowvin = 1'b1; cyc(1); clr_lowvin = 1'b0;
                    chk("R5 own clear stat", stat[8], 0);
                    chk("R5 own clear alert", alert_n, 1);
                end else begin
                    cyc(1);
                    chk("R7 no event", alert_n, 1);
                end
            end
        end
        vin_lower = 1'b0; vin_sel91 = 1'b0;

        // R5: clear strobe while low voltage persists
        vbus_lvl = 8'd100; cyc(10);
        clr_lowvin = 1'b1; cyc(1); clr_lowvin = 1'b0;
        chk("R5 clear while active", stat[8], 1);
        chk("R5 alert stays", alert_n, 0);
        host_clr(); cyc(1);
        chk("R5 alert clear ignored", stat[8], 1);
        vbus_lvl = 8'd255;
        clr_lowvin = 1'b1; cyc(1); clr_lowvin = 1'b0;
        chk("R5 clear after active", stat[8], 0);

        // R6: exit event with every enable off
        ev_en = 10'h000; cyc(2);
        exit_assist = 1'b1; cyc(1); exit_assist = 1'b0; cyc(30);
        chk("R6 exit always stat", stat[9], 1);
        chk("R6 exit always alert", alert_n, 0);
        host_clr(); cyc(1);
        chk("R5 exit ignores alert clear", alert_n, 0);
        clr_exit = 1'b1; cyc(1); clr_exit = 1'b0;
        chk("R5 exit clear stat", stat[9], 0);
        chk("R5 exit clear alert", alert_n, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule